// File: doc/BRIEF.md
# Write-Only Serial Register Target for a Tuning Synthesizer

This block is a write-only target on a two-wire serial bus. It loads the settings of a frequency synthesizer and of three audio channels: an 11-bit programmable divider ratio, a charge-pump current select bit, a 3-bit channel mute field and a 3-bit test-mode field. The clock and data lines are sampled by a fast system clock through synchronizers and a glitch filter. The block detects start and stop conditions, shifts in bytes on rising clock edges and acknowledges by pulling the data line low through an open-drain output.

A telegram opens with an address byte, and a strap input selects between two accepted addresses. Each data byte declares its own type through its most significant bit. A 1 marks a control byte. A 0 marks the first of two divider bytes, and the byte that follows it is always taken as the second divider byte. Divider bytes are staged and reach the output word together. If a telegram ends after only the first divider byte, only the upper bits of the word are replaced.

Top module: `sif_i2c_wr_slave`

## Requirements
- R1: A falling data line while the clock is high (start) restarts byte framing and waits for an address byte. A rising data line while the clock is high (stop) returns the block to idle. Both take effect in the middle of any telegram.
- R2: The address byte, sent MSB first, is accepted when it equals 0x44 with `addr_sel`=0 or 0x46 with `addr_sel`=1. Its last bit is the direction bit and must be 0. On acceptance `sda_pd_o` is 1 while the clock is high on the ninth clock.
- R3: An address byte that does not match, or that has its direction bit set to 1, gets no acknowledge. All bytes after it up to the next start are neither acknowledged nor applied.
- R4: After reset `sda_pd_o` stays 0 until an accepted address byte has been received.
- R5: Every data byte after an accepted address is acknowledged on its ninth clock.
- R6: A data byte with bit 7 = 1 that does not complete a divider pair is a control byte. It sets `pump_hi` from bit 6, `mute` from bits 5:3 and `test_mode` from bits 2:0.
- R7: A data byte with bit 7 = 0 is the upper divider byte. Its bits 5:0 are staged and `div_word` does not change yet. The next byte is the lower divider byte whatever its bit 7. On that byte `div_word` becomes {upper[5:0], lower[7:3]}.
- R8: The orders address, upper, lower, control and address, control, upper, lower both apply every field.
- R9: If a stop or start follows an upper divider byte with no lower byte, `div_word[10:5]` takes the staged bits and `div_word[4:0]` keeps its previous value.
- R10: Reset gives `div_word`=1024, `pump_hi`=0, `mute`=0, `test_mode`=0 and `sda_pd_o`=0.
- R11: A pulse on either line that is shorter than FILT_LEN system clocks is ignored. Such a pulse adds no bit and creates no start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 1 | Strap: 0 selects address byte 0x44, 1 selects 0x46 |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pd_o | output | 1 | 1 pulls the data line low (acknowledge) |
| div_word | output | 11 | Synthesizer divider ratio |
| pump_hi | output | 1 | Charge-pump high-current select |
| mute | output | 3 | Audio channel mute field |
| test_mode | output | 3 | Test-mode field |

## Verification
A wrong bit count or a bad start or stop decision shows at the ports within one byte. The acknowledge pulse lands on the wrong clock, or a wrong byte value appears in `mute`, `test_mode` or `div_word` once that byte has been acknowledged. A wrong divider type flag only shows on the byte after the upper divider byte, or at the stop that ends the telegram. The bench therefore reads the outputs after each byte and again after each stop. A filter that lets glitches through adds a bit or ends the telegram early, which corrupts the field being loaded in that same byte.

// File: rtl/sif_i2c_pkg.sv
package sif_i2c_pkg;
   typedef enum logic [1:0] {
      BUS_IDLE = 2'd0,
      BUS_ADDR = 2'd1,
      BUS_DATA = 2'd2,
      BUS_SKIP = 2'd3
   } bus_st_t;

   localparam int BYTE_W      = 8;
   localparam int TYPE_BIT    = 7;   // 1: control byte, 0: upper divider byte
   localparam int PUMP_BIT    = 6;
   localparam int FLD_W       = 3;
   localparam int MUTE_LSB    = 3;
   localparam int TEST_LSB    = 0;
   localparam int STAGE_W     = BYTE_W - 1;
endpackage

// File: rtl/sif_i2c_filt.sv
module sif_i2c_filt #(
   parameter int N_LINES     = 2,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] raw,
   output logic [N_LINES-1:0] clean
);
   localparam int CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("sif_i2c_filt: SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 0 || FILT_LEN > 64) begin : g_bad_filt
      $error("sif_i2c_filt: FILT_LEN must lie in 0..64");
   end

   for (genvar i = 0; i < N_LINES; i++) begin : g_line
      logic [SYNC_STAGES-1:0] sync_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '1;
         else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw[i]};
      end

      if (FILT_LEN == 0) begin : g_bypass
         assign clean[i] = sync_q[SYNC_STAGES-1];
      end else begin : g_count
         logic          level_q;
         logic [CW-1:0] run_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               level_q <= 1'b1;
               run_q   <= '0;
            end else if (sync_q[SYNC_STAGES-1] != level_q) begin
               if (run_q == CW'(FILT_LEN - 1)) begin
                  level_q <= sync_q[SYNC_STAGES-1];
                  run_q   <= '0;
               end else begin
                  run_q <= run_q + 1'b1;
               end
            end else begin
               run_q <= '0;
            end
         end
         assign clean[i] = level_q;
      end
   end
endmodule

// File: rtl/sif_i2c_bitctl.sv
module sif_i2c_bitctl
   import sif_i2c_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda,
   input  logic              frame_clr,
   input  logic              ack_req,
   output logic              byte_done,
   output logic [BYTE_W-1:0] byte_val,
   output logic              pull_low
);
   logic [3:0] cnt_q;
   logic       ack_pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         byte_val   <= '0;
         byte_done  <= 1'b0;
         ack_pend_q <= 1'b0;
         pull_low   <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         if (byte_done) ack_pend_q <= ack_req;
         if (frame_clr) begin
            cnt_q      <= '0;
            ack_pend_q <= 1'b0;
            pull_low   <= 1'b0;
         end else if (scl_rise) begin
            if (cnt_q < 4'd8) begin
               byte_val <= {byte_val[BYTE_W-2:0], sda};
               cnt_q    <= cnt_q + 4'd1;
               if (cnt_q == 4'd7) byte_done <= 1'b1;
            end else if (cnt_q == 4'd8) begin
               cnt_q <= 4'd9;
            end
         end else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
               pull_low <= ack_pend_q;
            end else if (cnt_q == 4'd9) begin
               pull_low   <= 1'b0;
               ack_pend_q <= 1'b0;
               cnt_q      <= '0;
            end
         end
      end
   end
endmodule

// File: rtl/sif_i2c_latch.sv
module sif_i2c_latch
   import sif_i2c_pkg::*;
#(
   parameter int HI_W    = 6,
   parameter int LO_W    = 5,
   parameter int RST_DIV = 1024
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 data_vld,
   input  logic [BYTE_W-1:0]    data,
   input  logic                 tel_end,
   output logic [HI_W+LO_W-1:0] div_word,
   output logic                 pump_hi,
   output logic [FLD_W-1:0]     mute,
   output logic [FLD_W-1:0]     test_mode
);
   localparam int DIV_W = HI_W + LO_W;
   localparam int LO_SH = BYTE_W - LO_W;

   if (HI_W < 1 || HI_W > STAGE_W - 1) begin : g_bad_hi
      $error("sif_i2c_latch: HI_W must lie in 1..6");
   end
   if (LO_W < 1 || LO_W > BYTE_W) begin : g_bad_lo
      $error("sif_i2c_latch: LO_W must lie in 1..8");
   end

   logic [STAGE_W-1:0] stage_q;
   logic               want_lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q   <= '0;
         want_lo_q <= 1'b0;
         div_word  <= DIV_W'(RST_DIV);
         pump_hi   <= 1'b0;
         mute      <= '0;
         test_mode <= '0;
      end else if (data_vld) begin
         if (want_lo_q) begin
            div_word  <= DIV_W'({stage_q, data} >> LO_SH);
            want_lo_q <= 1'b0;
         end else if (data[TYPE_BIT]) begin
            pump_hi   <= data[PUMP_BIT];
            mute      <= data[MUTE_LSB +: FLD_W];
            test_mode <= data[TEST_LSB +: FLD_W];
         end else begin
            stage_q   <= data[STAGE_W-1:0];
            want_lo_q <= 1'b1;
         end
      end else if (tel_end && want_lo_q) begin
         div_word  <= DIV_W'({stage_q, div_word[LO_W-1:0]});
         want_lo_q <= 1'b0;
      end
   end
endmodule

// File: rtl/sif_i2c_wr_slave.sv
module sif_i2c_wr_slave
   import sif_i2c_pkg::*;
#(
   parameter int       SYNC_STAGES = 2,
   parameter int       FILT_LEN    = 4,
   parameter logic [6:0] ADDR_BASE = 7'h22,
   parameter int       HI_W        = 6,
   parameter int       LO_W        = 5,
   parameter int       RST_DIV     = 1024
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 addr_sel,
   input  logic                 scl_i,
   input  logic                 sda_i,
   output logic                 sda_pd_o,
   output logic [HI_W+LO_W-1:0] div_word,
   output logic                 pump_hi,
   output logic [2:0]           mute,
   output logic [2:0]           test_mode
);
   if (FLD_W != 3) begin : g_bad_fld
      $error("sif_i2c_wr_slave: field width mismatch");
   end

   logic [1:0]        line_f;
   logic              scl_f, sda_f, scl_d, sda_d;
   logic              scl_rise, scl_fall, start_c, stop_c, tel_end;
   logic              byte_done, ack_req, data_vld;
   logic [BYTE_W-1:0] byte_val;
   logic [BYTE_W-1:0] own_addr;
   bus_st_t           st;

   sif_i2c_filt #(
      .N_LINES(2), .SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)
   ) i_filt (
      .clk(clk), .rst_n(rst_n), .raw({scl_i, sda_i}), .clean(line_f)
   );
   assign scl_f = line_f[1];
   assign sda_f = line_f[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_f;
         sda_d <= sda_f;
      end
   end

   assign scl_rise = scl_f & ~scl_d;
   assign scl_fall = ~scl_f & scl_d;
   assign start_c  = scl_f & scl_d & sda_d & ~sda_f;
   assign stop_c   = scl_f & scl_d & ~sda_d & sda_f;
   assign tel_end  = start_c | stop_c;

   assign own_addr = {ADDR_BASE[6:1], ADDR_BASE[0] | addr_sel, 1'b0};
   assign ack_req  = (st == BUS_DATA) || (st == BUS_ADDR && byte_val == own_addr);
   assign data_vld = byte_done && (st == BUS_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          st <= BUS_IDLE;
      else if (start_c)    st <= BUS_ADDR;
      else if (stop_c)     st <= BUS_IDLE;
      else if (byte_done && st == BUS_ADDR)
         st <= (byte_val == own_addr) ? BUS_DATA : BUS_SKIP;
   end

   sif_i2c_bitctl i_bits (
      .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .sda(sda_f), .frame_clr(tel_end), .ack_req(ack_req),
      .byte_done(byte_done), .byte_val(byte_val), .pull_low(sda_pd_o)
   );

   sif_i2c_latch #(
      .HI_W(HI_W), .LO_W(LO_W), .RST_DIV(RST_DIV)
   ) i_latch (
      .clk(clk), .rst_n(rst_n), .data_vld(data_vld), .data(byte_val),
      .tel_end(tel_end), .div_word(div_word), .pump_hi(pump_hi),
      .mute(mute), .test_mode(test_mode)
   );
endmodule

// File: rtl/sif_i2c_wr_slave_chk.sv
module sif_i2c_wr_slave_chk
   import sif_i2c_pkg::*;
#(
   parameter int DIV_W = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic             scl_f,
   input bus_st_t          st,
   input logic             sda_pd_o,
   input logic             data_vld,
   input logic             tel_end,
   input logic [DIV_W-1:0] div_word,
   input logic             pump_hi,
   input logic [2:0]       mute,
   input logic [2:0]       test_mode
);
   p_no_pull_unaddressed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == BUS_IDLE || st == BUS_SKIP) |-> !sda_pd_o);

   p_pull_only_after_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pd_o) |-> st == BUS_DATA);

   p_pull_starts_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pd_o) |-> !scl_f);

   p_div_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!data_vld && !tel_end) |=> $stable(div_word));

   p_ctl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !data_vld |=> $stable({pump_hi, mute, test_mode}));
endmodule

bind sif_i2c_wr_slave sif_i2c_wr_slave_chk #(.DIV_W(HI_W + LO_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .st(st), .sda_pd_o(sda_pd_o),
   .data_vld(data_vld), .tel_end(tel_end), .div_word(div_word),
   .pump_hi(pump_hi), .mute(mute), .test_mode(test_mode)
);

// File: tb/test_sif_i2c_wr_slave.sv
`timescale 1ns/1ps
module test_sif_i2c_wr_slave;
   localparam int Q = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        addr_sel = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic        sda_pd_o;
   logic        sda_bus;
   logic [10:0] div_word;
   logic        pump_hi;
   logic [2:0]  mute, test_mode;
   int          errors = 0;
   int          checks = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;
   assign sda_bus = sda_m & ~sda_pd_o;

   sif_i2c_wr_slave i_sif_i2c_wr_slave (
      .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_i(scl_m),
      .sda_i(sda_bus), .sda_pd_o(sda_pd_o), .div_word(div_word),
      .pump_hi(pump_hi), .mute(mute), .test_mode(test_mode)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wait_clk(Q);
      scl_m = 1'b1; wait_clk(2*Q);
      sda_m = 1'b0; wait_clk(2*Q);
      scl_m = 1'b0; wait_clk(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wait_clk(Q);
      scl_m = 1'b1; wait_clk(2*Q);
      sda_m = 1'b1; wait_clk(2*Q);
   endtask

   // Sends one byte MSB first, returns the acknowledge seen on the ninth clock.
   task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         wait_clk(Q);
         sda_m = b[i];
         if (glitch && i == 4) begin
            wait_clk(10); scl_m = 1'b1; wait_clk(2); scl_m = 1'b0; wait_clk(Q-12);
         end else begin
            wait_clk(Q);
         end
         scl_m = 1'b1;
         if (glitch && i == 2) begin
            wait_clk(Q); sda_m = ~b[i]; wait_clk(2); sda_m = b[i]; wait_clk(Q-2);
         end else begin
            wait_clk(2*Q);
         end
         scl_m = 1'b0;
      end
      wait_clk(Q);
      sda_m = 1'b1;
      wait_clk(Q);
      scl_m = 1'b1;
      wait_clk(Q);
      ack = sda_pd_o;
      wait_clk(Q);
      scl_m = 1'b0;
   endtask

   task automatic t_reset();
      check("R10 div_word", div_word, 1024);
      check("R10 pump_hi", pump_hi, 0);
      check("R10 mute", mute, 0);
      check("R10 test_mode", test_mode, 0);
      check("R4 no pull after reset", sda_pd_o, 0);
   endtask

   task automatic t_mismatch();
      bit a;
      addr_sel = 1'b0;
      bus_start();
      send_byte(8'h46, 0, a); check("R3 wrong address no ack", a, 0);
      send_byte(8'hFF, 0, a); check("R3 later byte no ack", a, 0);
      bus_stop();
      check("R3 mute untouched", mute, 0);
      check("R3 pump untouched", pump_hi, 0);
      bus_start();
      send_byte(8'h45, 0, a); check("R3 read direction no ack", a, 0);
      bus_stop();
      check("R4 idle no pull", sda_pd_o, 0);
   endtask

   task automatic t_div_then_ctl();
      bit a;
      addr_sel = 1'b0;
      bus_start();
      send_byte(8'h44, 0, a); check("R2 address 0x44 ack", a, 1);
      send_byte(8'h2E, 0, a); check("R5 upper byte ack", a, 1);
      check("R7 div staged not applied", div_word, 1024);
      send_byte(8'hE0, 0, a); check("R5 lower byte ack", a, 1);
      check("R7 div pair applied", div_word, 1500);
      send_byte(8'hC5, 0, a); check("R5 control ack", a, 1);
      check("R8 pump_hi", pump_hi, 1);
      check("R8 mute", mute, 0);
      check("R8 test_mode", test_mode, 5);
      bus_stop();
      check("R1 stop leaves no pull", sda_pd_o, 0);
   endtask

   task automatic t_ctl_then_div();
      bit a;
      addr_sel = 1'b1;
      bus_start();
      send_byte(8'h46, 0, a); check("R2 address 0x46 ack", a, 1);
      send_byte(8'h9A, 0, a);
      check("R6 pump_hi", pump_hi, 0);
      check("R6 mute", mute, 3);
      check("R6 test_mode", test_mode, 2);
      send_byte(8'h3F, 0, a);
      send_byte(8'hF8, 0, a); check("R5 lower ack", a, 1);
      check("R8 div after control", div_word, 2047);
      bus_stop();
   endtask

   task automatic t_partial();
      bit a;
      addr_sel = 1'b1;
      bus_start();
      send_byte(8'h46, 0, a);
      send_byte(8'h20, 0, a);
      check("R9 div before stop", div_word, 2047);
      bus_stop();
      wait_clk(20);
      check("R9 upper only after stop", div_word, 1055);
      bus_start();
      send_byte(8'h46, 0, a);
      send_byte(8'hA8, 0, a);
      bus_stop();
      check("R6 lone control mute", mute, 5);
      check("R6 lone control test", test_mode, 0);
      check("R9 div kept over control", div_word, 1055);
   endtask

   task automatic t_glitch();
      bit a;
      addr_sel = 1'b0;
      bus_start();
      send_byte(8'h44, 0, a);
      send_byte(8'hB1, 1, a); check("R11 ack after glitches", a, 1);
      check("R11 mute", mute, 6);
      check("R11 test_mode", test_mode, 1);
      bus_stop();
   endtask

   task automatic t_restart();
      bit a;
      addr_sel = 1'b0;
      bus_start();
      send_byte(8'h44, 0, a);
      send_byte(8'h01, 0, a);
      bus_start();
      wait_clk(5);
      check("R1 R9 repeated start commits upper", div_word, 63);
      send_byte(8'h44, 0, a); check("R1 address after repeated start", a, 1);
      send_byte(8'h87, 0, a);
      check("R1 control after restart", test_mode, 7);
      check("R1 div unchanged by control", div_word, 63);
      bus_stop();
   endtask

   initial begin
      wait_clk(10);
      rst_n = 1'b1;
      wait_clk(10);
      t_reset();
      t_mismatch();
      t_div_then_ctl();
      t_ctl_then_div();
      t_partial();
      t_glitch();
      t_restart();
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule